// File: doc/BRIEF.md
# Inter-Peer Doorbell Register Block

This block is a small 32-bit register slave that sits between a local host and a fabric of cooperating peers. The host uses it for three things: to ring a remote peer on a chosen vector, to learn its own position among the peers, and to collect and acknowledge events that other peers aimed at it. The window spans 256 bytes and holds four word registers: an interrupt enable mask, an event status word, a read-only own-position word and a write-only doorbell.

A doorbell write packs the target peer into the upper half-word and the vector into the low byte. The block checks the target against the number of peers that are currently connected, and the vector against the number of vectors that peer has registered. Both tables are supplied on input ports by the surrounding logic. A write that passes both checks leaves the block as a single-cycle notify pulse carrying the target and the vector. A write that fails either check disappears without a trace. An incoming event for the local peer loads the value 1 into the status word. A level interrupt stays high while any status bit is also enabled in the mask. Reading the status word returns it and clears it in the same access.

Top module: `peer_bell_regs`

## Requirements
- R1: While reset is held and in the cycle after it is released, mask, status, `irq` and `ring_valid` are all zero.
- R2: A write to the mask (offset 0x00) or status (offset 0x04) loads the full 32-bit write data. The write decoder ignores address bits 1:0, so a write to 0x02 lands in the mask and a write to 0x05 lands in the status.
- R3: A read at offset 0x04 returns the status value held before the read and leaves the status at zero, so an immediate second read returns 0.
- R4: Read data and `bus_rvalid` appear one cycle after `bus_rd`. Reads decode the full byte address: 0x00 returns the mask, 0x04 the status, 0x08 the own position zero-extended, and every other offset, unaligned ones included, returns 0. Any read at an offset other than 0x04 leaves the status unchanged.
- R5: A write whose masked address is 0x0C, with target `wdata[31:16]` and vector `wdata[7:0]`, that passes both checks raises `ring_valid` for exactly one cycle, one cycle after the write, with `ring_dest` and `ring_vec` equal to those fields.
- R6: A doorbell whose target is not below `live_peers` produces no pulse and changes neither mask nor status.
- R7: A doorbell whose vector is not below the target's entry in `peer_vec_counts` (9 bits per peer, peer p at bits 9p+8:9p) produces no pulse.
- R8: A cycle with `evt_in` high leaves the status equal to exactly 1. Any previous status bits are discarded.
- R9: `irq` is high exactly when the bitwise AND of status and mask is nonzero, and it tracks register changes in the same cycle they happen.
- R10: Within one cycle, an event has priority over a status write, and a status write has priority over a read-clear. The read still returns the old value.
- R11: Writes to the own-position offset (0x08) or to any undefined offset such as 0x10 or 0xFC change no readable state and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address inside the window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| own_pos | input | 16 | Position of the local peer |
| live_peers | input | 5 | Number of connected peers |
| peer_vec_counts | input | 144 | Registered vector count per peer, 9 bits each |
| evt_in | input | 1 | Event for the local peer |
| ring_valid | output | 1 | Single-cycle notify pulse |
| ring_dest | output | 16 | Target peer of the pulse |
| ring_vec | output | 8 | Vector of the pulse |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are the collisions inside one cycle: an event, a status write and a status read-clear all arriving together. Sequential accesses never produce them. The bench therefore drives its bus strobes and `evt_in` through one cycle task that can raise any combination of them at the same clock edge. It then reads the status back through the normal read port to see which action won. The doorbell checks are reached by loading a vector table in which one peer beyond the live count has a nonzero count and another live peer has the maximum count of 256. That separates the target check from the vector check, and it also exercises the vector field at its top value of 255.

// File: rtl/peer_bell_pkg.sv
package peer_bell_pkg;
  // Register offsets inside the 256-byte window
  localparam int OFF_MASK = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_POS  = 'h08;
  localparam int OFF_BELL = 'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT,
    SEL_POS,
    SEL_BELL
  } reg_sel_e;
endpackage

// File: rtl/pb_decode.sv
module pb_decode
  import peer_bell_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          wr_sel,
  output reg_sel_e          rd_sel
);
  logic [ADDR_W-1:0] waddr;

  // write path drops the byte-lane bits, read path keeps them
  assign waddr = {addr[ADDR_W-1:2], 2'b00};

  always_comb begin
    wr_sel = SEL_NONE;
    if (waddr == ADDR_W'(OFF_MASK))      wr_sel = SEL_MASK;
    else if (waddr == ADDR_W'(OFF_STAT)) wr_sel = SEL_STAT;
    else if (waddr == ADDR_W'(OFF_POS))  wr_sel = SEL_POS;
    else if (waddr == ADDR_W'(OFF_BELL)) wr_sel = SEL_BELL;
  end

  always_comb begin
    rd_sel = SEL_NONE;
    if (addr == ADDR_W'(OFF_MASK))      rd_sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_STAT)) rd_sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_POS))  rd_sel = SEL_POS;
  end
endmodule

// File: rtl/pb_status.sv
module pb_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic              evt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] stat_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = wdata;
  end

  // later assignments win: event > write > read-clear
  always_comb begin
    stat_d = stat_q;
    if (rd_stat) stat_d = '0;
    if (wr_stat) stat_d = wdata;
    if (evt)     stat_d = DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= |(stat_d & mask_d);
    end
  end
endmodule

// File: rtl/pb_bell.sv
module pb_bell #(
  parameter int NUM_PEERS = 16,
  parameter int NUM_VECS  = 256,
  parameter int DEST_W    = 16,
  parameter int VEC_W     = 8,
  parameter int PCW       = $clog2(NUM_PEERS + 1),
  parameter int VCW       = $clog2(NUM_VECS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic [DEST_W-1:0]        dest,
  input  logic [VEC_W-1:0]         vec,
  input  logic [PCW-1:0]           live_peers,
  input  logic [NUM_PEERS*VCW-1:0] vec_counts,
  output logic                     ring_valid,
  output logic [DEST_W-1:0]        ring_dest,
  output logic [VEC_W-1:0]         ring_vec
);
  logic [NUM_PEERS-1:0] hit;
  logic                 pass;

  // one comparator slice per peer slot
  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_peer
    logic [VCW-1:0] cnt;
    logic           is_dest;
    logic           is_live;
    logic           vec_ok;
    assign cnt     = vec_counts[p*VCW +: VCW];
    assign is_dest = (dest == DEST_W'(p));
    assign is_live = (PCW'(p) < live_peers);
    assign vec_ok  = (int'(vec) < int'(cnt)) && (int'(vec) < NUM_VECS);
    assign hit[p]  = is_dest && is_live && vec_ok;
  end

  assign pass = fire && (|hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_valid <= 1'b0;
      ring_dest  <= '0;
      ring_vec   <= '0;
    end else begin
      ring_valid <= pass;
      if (pass) begin
        ring_dest <= dest;
        ring_vec  <= vec;
      end
    end
  end
endmodule

// File: rtl/pb_rdmux.sv
module pb_rdmux
  import peer_bell_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  reg_sel_e          rd_sel,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] stat,
  input  logic [POS_W-1:0]  own_pos,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    case (rd_sel)
      SEL_MASK: rd_d = mask;
      SEL_STAT: rd_d = stat;
      SEL_POS:  rd_d = DATA_W'(own_pos);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_d;
    end
  end
endmodule

// File: rtl/peer_bell_regs.sv
module peer_bell_regs
  import peer_bell_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int NUM_VECS  = 256,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DEST_W    = 16,
  parameter int VEC_W     = 8,
  parameter int POS_W     = 16,
  localparam int PCW      = $clog2(NUM_PEERS + 1),
  localparam int VCW      = $clog2(NUM_VECS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [POS_W-1:0]         own_pos,
  input  logic [PCW-1:0]           live_peers,
  input  logic [NUM_PEERS*VCW-1:0] peer_vec_counts,
  input  logic                     evt_in,
  output logic                     ring_valid,
  output logic [DEST_W-1:0]        ring_dest,
  output logic [VEC_W-1:0]         ring_vec,
  output logic                     irq
);
  reg_sel_e          wr_sel;
  reg_sel_e          rd_sel;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] stat_q;
  logic              wr_mask;
  logic              wr_stat;
  logic              rd_stat;
  logic              bell_fire;

  pb_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr  (bus_addr),
    .wr_sel(wr_sel),
    .rd_sel(rd_sel)
  );

  assign wr_mask   = bus_wr && (wr_sel == SEL_MASK);
  assign wr_stat   = bus_wr && (wr_sel == SEL_STAT);
  assign rd_stat   = bus_rd && (rd_sel == SEL_STAT);
  assign bell_fire = bus_wr && (wr_sel == SEL_BELL);

  pb_status #(.DATA_W(DATA_W)) stat_i (
    .clk    (clk),
    .rst    (rst),
    .wr_mask(wr_mask),
    .wr_stat(wr_stat),
    .rd_stat(rd_stat),
    .evt    (evt_in),
    .wdata  (bus_wdata),
    .mask_q (mask_q),
    .stat_q (stat_q),
    .irq_q  (irq)
  );

  pb_bell #(
    .NUM_PEERS(NUM_PEERS),
    .NUM_VECS (NUM_VECS),
    .DEST_W   (DEST_W),
    .VEC_W    (VEC_W),
    .PCW      (PCW),
    .VCW      (VCW)
  ) bell_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (bell_fire),
    .dest      (bus_wdata[DATA_W-1 -: DEST_W]),
    .vec       (bus_wdata[VEC_W-1:0]),
    .live_peers(live_peers),
    .vec_counts(peer_vec_counts),
    .ring_valid(ring_valid),
    .ring_dest (ring_dest),
    .ring_vec  (ring_vec)
  );

  pb_rdmux #(.DATA_W(DATA_W), .POS_W(POS_W)) rdm_i (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .rd_sel  (rd_sel),
    .mask    (mask_q),
    .stat    (stat_q),
    .own_pos (own_pos),
    .rdata_q (bus_rdata),
    .rvalid_q(bus_rvalid)
  );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int NUM_PEERS = 16,
  localparam int PCW      = $clog2(NUM_PEERS + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic [7:0]     bus_addr,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic           evt_in,
  input logic [PCW-1:0] live_peers,
  input logic           ring_valid,
  input logic [15:0]    ring_dest,
  input logic           bus_rvalid,
  input logic           irq,
  input logic [31:0]    mask_q,
  input logic [31:0]    stat_q
);
  logic warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (mask_q == 32'd0 && stat_q == 32'd0 && !irq && !ring_valid));

  // R3
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst || !warm)
    $past(bus_rd && bus_addr == 8'h04 && !bus_wr && !evt_in) |-> stat_q == 32'd0);

  // R4
  a_r4_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R5
  a_r5_pulse_has_write: assert property (@(posedge clk) disable iff (rst || !warm)
    ring_valid |-> $past(bus_wr && bus_addr[7:2] == 6'h03));

  // R6
  a_r6_dest_live: assert property (@(posedge clk) disable iff (rst || !warm)
    ring_valid |-> int'(ring_dest) < int'($past(live_peers)));

  // R8
  a_r8_event_loads_one: assert property (@(posedge clk) disable iff (rst || !warm)
    $past(evt_in) |-> stat_q == 32'd1);

  // R9
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (|(stat_q & mask_q)));
endmodule

bind peer_bell_regs pb_checker #(.NUM_PEERS(NUM_PEERS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .evt_in    (evt_in),
  .live_peers(live_peers),
  .ring_valid(ring_valid),
  .ring_dest (ring_dest),
  .bus_rvalid(bus_rvalid),
  .irq       (irq),
  .mask_q    (mask_q),
  .stat_q    (stat_q)
);

// File: tb/peer_bell_regs_tb_top.sv
module peer_bell_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic [7:0]   bus_addr;
  logic         bus_wr;
  logic         bus_rd;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [15:0]  own_pos;
  logic [4:0]   live_peers;
  logic [143:0] peer_vec_counts;
  logic         evt_in;
  logic         ring_valid;
  logic [15:0]  ring_dest;
  logic [7:0]   ring_vec;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  peer_bell_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .own_pos(own_pos), .live_peers(live_peers), .peer_vec_counts(peer_vec_counts),
    .evt_in(evt_in), .ring_valid(ring_valid), .ring_dest(ring_dest),
    .ring_vec(ring_vec), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // one bus cycle; outputs of the edge are sampled on return
  task automatic cyc(input logic [7:0] a, input logic w, input logic r,
                     input logic [31:0] d, input logic e);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; evt_in = e;
    @(negedge clk);
    bus_addr = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 32'd0; evt_in = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(a, 1'b1, 1'b0, d, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    cyc(a, 1'b0, 1'b1, 32'd0, 1'b0);
    v = bus_rdata;
    chk("R4 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 ring_valid", 32'(ring_valid), 32'd0);
    rd(8'h00, v); chk("R1 mask", v, 32'd0);
    rd(8'h04, v); chk("R1 status", v, 32'd0);
  endtask

  task automatic t_mask_status();
    logic [31:0] v;
    wr(8'h02, 32'hA5A5_00FF);
    rd(8'h00, v); chk("R2 mask via 0x02", v, 32'hA5A5_00FF);
    wr(8'h05, 32'h0000_0100);
    chk("R9 irq off, no overlap", 32'(irq), 32'd0);
    rd(8'h04, v); chk("R2 status via 0x05", v, 32'h0000_0100);
    wr(8'h04, 32'h0000_0001);
    chk("R9 irq on overlap", 32'(irq), 32'd1);
    rd(8'h04, v); chk("R3 read returns", v, 32'd1);
    chk("R9 irq drops after clear", 32'(irq), 32'd0);
    rd(8'h04, v); chk("R3 second read zero", v, 32'd0);
  endtask

  task automatic t_read_decode();
    logic [31:0] v;
    rd(8'h08, v); chk("R4 own position", v, 32'h0000_0007);
    wr(8'h04, 32'h0000_0033);
    rd(8'h05, v); chk("R4 unaligned read zero", v, 32'd0);
    rd(8'h09, v); chk("R4 unaligned pos zero", v, 32'd0);
    rd(8'h40, v); chk("R4 undefined read zero", v, 32'd0);
    rd(8'h0C, v); chk("R4 bell read zero", v, 32'd0);
    rd(8'h04, v); chk("R4 status kept by other reads", v, 32'h0000_0033);
  endtask

  task automatic t_undef_write();
    logic [31:0] v;
    wr(8'h00, 32'h0000_1234);
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R11 no pulse", 32'(ring_valid), 32'd0);
    rd(8'h08, v); chk("R11 position read-only", v, 32'h0000_0007);
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'hFC, 32'hCAFE_F00D);
    rd(8'h00, v); chk("R11 mask untouched", v, 32'h0000_1234);
    rd(8'h04, v); chk("R11 status untouched", v, 32'd0);
  endtask

  task automatic t_bell_ok();
    wr(8'h0C, 32'h0001_00FF);
    chk("R5 pulse", 32'(ring_valid), 32'd1);
    chk("R5 dest", 32'(ring_dest), 32'd1);
    chk("R5 vec top", 32'(ring_vec), 32'd255);
    @(negedge clk);
    chk("R5 one cycle", 32'(ring_valid), 32'd0);
    wr(8'h0E, 32'h0000_AB01);
    chk("R5 pulse masked addr", 32'(ring_valid), 32'd1);
    chk("R5 dest0", 32'(ring_dest), 32'd0);
    chk("R5 vec1", 32'(ring_vec), 32'd1);
  endtask

  task automatic t_bell_bad_dest();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0000);
    wr(8'h0C, 32'h0003_0000);
    chk("R6 dest at live count", 32'(ring_valid), 32'd0);
    wr(8'h0C, 32'h8000_0000);
    chk("R6 dest huge", 32'(ring_valid), 32'd0);
    rd(8'h00, v); chk("R6 mask untouched", v, 32'd0);
    rd(8'h04, v); chk("R6 status untouched", v, 32'd0);
  endtask

  task automatic t_bell_bad_vec();
    wr(8'h0C, 32'h0000_0002);
    chk("R7 vec at count", 32'(ring_valid), 32'd0);
    wr(8'h0C, 32'h0002_0001);
    chk("R7 vec past single", 32'(ring_valid), 32'd0);
    wr(8'h0C, 32'h0002_0000);
    chk("R7 vec inside single", 32'(ring_valid), 32'd1);
  endtask

  task automatic t_event();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0001);
    wr(8'h04, 32'h0000_00F0);
    chk("R9 no overlap before event", 32'(irq), 32'd0);
    cyc(8'h00, 1'b0, 1'b0, 32'd0, 1'b1);
    chk("R9 irq on event", 32'(irq), 32'd1);
    rd(8'h04, v); chk("R8 event loads one", v, 32'd1);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    cyc(8'h04, 1'b1, 1'b0, 32'h0000_0055, 1'b1);
    rd(8'h04, v); chk("R10 event beats write", v, 32'd1);
    wr(8'h04, 32'h0000_0077);
    cyc(8'h04, 1'b0, 1'b1, 32'd0, 1'b1);
    chk("R10 read returns old", bus_rdata, 32'h0000_0077);
    rd(8'h04, v); chk("R10 event beats clear", v, 32'd1);
    wr(8'h04, 32'h0000_0066);
    cyc(8'h04, 1'b1, 1'b1, 32'h0000_0099, 1'b0);
    chk("R10 read old on write", bus_rdata, 32'h0000_0066);
    rd(8'h04, v); chk("R10 write beats clear", v, 32'h0000_0099);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; bus_addr = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 32'd0; evt_in = 1'b0; own_pos = 16'h0007; live_peers = 5'd3;
    peer_vec_counts = '0;
    peer_vec_counts[0*9 +: 9] = 9'd2;
    peer_vec_counts[1*9 +: 9] = 9'd256;
    peer_vec_counts[2*9 +: 9] = 9'd1;
    peer_vec_counts[3*9 +: 9] = 9'd5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask_status();
    t_read_decode();
    t_undef_write();
    t_bell_ok();
    t_bell_bad_dest();
    t_bell_bad_vec();
    t_event();
    t_priority();
    finish_run();
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule